// File: doc/BRIEF.md
# Masked Lockstep SIMD Processing Element

This block is one element of an array of identical elements driven by a single controller. Every element sees the same instruction at the same clock edge. Each instruction carries a 4-bit operation, an 11-bit address offset, a lane-width selector and a broadcast data word. The element adds its own index register to the offset, so elements can work on different local addresses while running the same program. It reads its private 2048 x 64-bit memory and updates its registers. These are an accumulator, a second-operand register, a scratch register, a routing register, the index register and an enable flag.

Arithmetic works on one full word, on two independent halves, or on eight independent bytes. Carries never cross a lane boundary. While the enable flag is clear, the element still takes part in the instruction stream but changes nothing. The only exception is the two instructions that set and clear the flag. The flag is driven back to the controller on a single wire. Every instruction takes exactly two cycles: an issue cycle in which the memory address is presented, and an execute cycle in which the read word is used and results are written. This fixed length keeps every element of the array in lockstep.

Top module: `lockstep_element`

## Requirements
- R1: After reset, `acc_out` and `route_out` are zero, `active_out` is 1, and `issue_ready` is 1.
- R2: Op 6 writes the accumulator to local memory at the effective address, and op 1 loads the accumulator from it. Any address 0 to 2047 keeps its own word.
- R3: The effective address is `issue_offset` plus the index register, modulo 2048. Op 9 copies the low 11 bits of the accumulator into the index register.
- R4: Op 3 adds the memory word to the accumulator lane by lane. `issue_lane` encodes the lanes as 0 for one 64-bit lane, 1 for two 32-bit lanes, 2 for eight 8-bit lanes and 3 for one 64-bit lane. No carry passes between lanes.
- R5: Op 4 subtracts the memory word from the accumulator lane by lane, using the same lane encoding as R4 and with no borrow passing between lanes.
- R6: Op 7 gives accumulator AND memory word, and op 8 gives accumulator XOR memory word. Op 2 loads the second-operand register from memory. Op 5 adds that register to the accumulator lane by lane, using the lane encoding of R4.
- R7: Op 10 copies the accumulator into the scratch register, and op 11 copies the scratch register back. Op 15 copies the accumulator into the routing register, which is visible on `route_out`.
- R8: While the element is inactive, every operation other than ops 12 and 13 leaves all registers and the local memory unchanged.
- R9: Op 12 sets the element active and op 13 sets it inactive, whatever its current state. `active_out` shows the flag.
- R10: An instruction accepted at one edge takes effect at the next edge, and `issue_ready` is low in between. An instruction offered while `issue_ready` is low is dropped and never executed.
- R11: The sequence "op 1 at base+1, op 3 at base+2, op 6 at base" leaves the sum of the two words at base.
- R12: Op 14 loads `bcast_word` into the accumulator. Op 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Broadcast instruction present |
| issue_op | input | 4 | Operation code |
| issue_offset | input | ADDR_W | Address offset before indexing |
| issue_lane | input | 2 | Lane width selector |
| bcast_word | input | WORD_W | Broadcast data word for op 14 |
| issue_ready | output | 1 | Element can accept an instruction |
| active_out | output | 1 | Enable flag returned to the controller |
| acc_out | output | WORD_W | Accumulator contents |
| route_out | output | WORD_W | Routing register contents |

## Verification
A corrupted enable flag shows on `active_out` at once. Its effect also shows one execute cycle later: the accumulator either moves when it should hold or holds when it should move. A wrong index register or a broken carry cut at a lane seam does not show on `acc_out` until the next load or add that goes through the affected address or lane. The sweeps therefore pair every lane width with operands whose carries reach each seam. A store done while the element is inactive is only exposed when the location is read back after the element is enabled again, so the bench reads it back.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
   typedef enum logic [3:0] {
      OP_NOP  = 4'd0,  OP_LDA  = 4'd1,  OP_LDB  = 4'd2,  OP_ADD  = 4'd3,
      OP_SUB  = 4'd4,  OP_ADDB = 4'd5,  OP_STA  = 4'd6,  OP_AND  = 4'd7,
      OP_XOR  = 4'd8,  OP_LDX  = 4'd9,  OP_SAVT = 4'd10, OP_RSTT = 4'd11,
      OP_ACTV = 4'd12, OP_IDLE = 4'd13, OP_LDI  = 4'd14, OP_MOVR = 4'd15
   } op_e;

   typedef enum logic [1:0] {
      LN_WORD = 2'd0, LN_HALF = 2'd1, LN_BYTE = 2'd2, LN_WIDE = 2'd3
   } lane_e;
endpackage

// File: rtl/lsp_local_ram.sv
module lsp_local_ram #(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
      if (rd_en) rd_data <= store[rd_addr];
   end
endmodule

// File: rtl/lsp_lane_adder.sv
module lsp_lane_adder
   import lsp_pkg::*;
#(
   parameter int WORD_W = 64
) (
   input  logic [WORD_W-1:0] opa,
   input  logic [WORD_W-1:0] opb,
   input  lane_e             lane,
   input  logic              sub,
   output logic [WORD_W-1:0] result
);
   localparam int NB   = WORD_W / 8;
   localparam int HALF = NB / 2;

   logic [WORD_W-1:0] opb_x;
   logic [NB-2:0]     cy;

   assign opb_x = sub ? ~opb : opb;

   for (genvar g = 0; g < NB; g++) begin : g_slice
      logic cin;
      if (g == 0) begin : g_first
         assign cin = sub;
      end else begin : g_rest
         logic seam;
         assign seam = (lane == LN_BYTE) || ((lane == LN_HALF) && (g == HALF));
         assign cin  = seam ? sub : cy[g-1];
      end
      if (g == NB - 1) begin : g_top
         assign result[g*8 +: 8] = opa[g*8 +: 8] + opb_x[g*8 +: 8] + {7'd0, cin};
      end else begin : g_mid
         assign {cy[g], result[g*8 +: 8]} =
            {1'b0, opa[g*8 +: 8]} + {1'b0, opb_x[g*8 +: 8]} + {8'd0, cin};
      end
   end
endmodule

// File: rtl/lockstep_element.sv
module lockstep_element
   import lsp_pkg::*;
#(
   parameter int   WORD_W       = 64,
   parameter int   ADDR_W       = 11,
   parameter logic RESET_ACTIVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   input  logic [3:0]        issue_op,
   input  logic [ADDR_W-1:0] issue_offset,
   input  logic [1:0]        issue_lane,
   input  logic [WORD_W-1:0] bcast_word,
   output logic              issue_ready,
   output logic              active_out,
   output logic [WORD_W-1:0] acc_out,
   output logic [WORD_W-1:0] route_out
);
   if (WORD_W < 16 || (WORD_W % 16) != 0) begin : g_bad_word
      $error("WORD_W must be a multiple of 16");
   end
   if (ADDR_W < 1 || ADDR_W > WORD_W) begin : g_bad_addr
      $error("ADDR_W must lie between 1 and WORD_W");
   end

   logic [WORD_W-1:0] acc_q, opb_q, tmp_q, route_q;
   logic [ADDR_W-1:0] idx_q;
   logic              mode_q;

   logic              ex_valid;
   op_e               ex_op;
   lane_e             ex_lane;
   logic [ADDR_W-1:0] ex_ea;
   logic [WORD_W-1:0] ex_bcast;

   logic              accept;
   logic [ADDR_W-1:0] ea;
   logic [WORD_W-1:0] mem_rd, alu_b, alu_sum;
   logic              ram_we;

   assign accept = issue_valid && !ex_valid;
   assign ea     = issue_offset + idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ex_valid <= 1'b0;
         ex_op    <= OP_NOP;
         ex_lane  <= LN_WORD;
         ex_ea    <= '0;
         ex_bcast <= '0;
      end else begin
         ex_valid <= accept;
         if (accept) begin
            ex_op    <= op_e'(issue_op);
            ex_lane  <= lane_e'(issue_lane);
            ex_ea    <= ea;
            ex_bcast <= bcast_word;
         end
      end
   end

   assign ram_we = ex_valid && mode_q && (ex_op == OP_STA);

   lsp_local_ram #(.DATA_W(WORD_W), .ADDR_W(ADDR_W)) ram_i (
      .clk     (clk),
      .rd_en   (accept),
      .rd_addr (ea),
      .rd_data (mem_rd),
      .wr_en   (ram_we),
      .wr_addr (ex_ea),
      .wr_data (acc_q)
   );

   assign alu_b = (ex_op == OP_ADDB) ? opb_q : mem_rd;

   lsp_lane_adder #(.WORD_W(WORD_W)) adder_i (
      .opa    (acc_q),
      .opb    (alu_b),
      .lane   (ex_lane),
      .sub    (ex_op == OP_SUB),
      .result (alu_sum)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         opb_q   <= '0;
         tmp_q   <= '0;
         route_q <= '0;
         idx_q   <= '0;
         mode_q  <= RESET_ACTIVE;
      end else if (ex_valid) begin
         if (ex_op == OP_ACTV) begin
            mode_q <= 1'b1;
         end else if (ex_op == OP_IDLE) begin
            mode_q <= 1'b0;
         end else if (mode_q) begin
            case (ex_op)
               OP_LDA:                 acc_q   <= mem_rd;
               OP_LDB:                 opb_q   <= mem_rd;
               OP_ADD, OP_SUB, OP_ADDB: acc_q  <= alu_sum;
               OP_AND:                 acc_q   <= acc_q & mem_rd;
               OP_XOR:                 acc_q   <= acc_q ^ mem_rd;
               OP_LDX:                 idx_q   <= acc_q[ADDR_W-1:0];
               OP_SAVT:                tmp_q   <= acc_q;
               OP_RSTT:                acc_q   <= tmp_q;
               OP_LDI:                 acc_q   <= ex_bcast;
               OP_MOVR:                route_q <= acc_q;
               default: ;
            endcase
         end
      end
   end

   assign issue_ready = !ex_valid;
   assign active_out  = mode_q;
   assign acc_out     = acc_q;
   assign route_out   = route_q;
endmodule

// File: rtl/lockstep_element_chk.sv
module lockstep_element_chk #(
   parameter int WORD_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_valid,
   input logic              issue_ready,
   input logic              ex_valid,
   input logic [3:0]        ex_op,
   input logic              mode_q,
   input logic              ram_we,
   input logic [WORD_W-1:0] acc_q,
   input logic [WORD_W-1:0] route_q
);
   logic mode_cmd;
   assign mode_cmd = ex_valid && (ex_op == 4'd12 || ex_op == 4'd13);

   // R10: execute cycle lasts exactly one cycle
   assert_single_exec_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ex_valid |=> !ex_valid);

   // R10: an offered instruction while ready is taken
   assert_issue_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_ready) |=> ex_valid);

   // R8: inactive element keeps its registers
   assert_inactive_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && !mode_q && !mode_cmd) |=> ($stable(acc_q) && $stable(route_q)));

   // R8: no memory write while inactive
   assert_no_store_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> mode_q);

   // R9: the flag moves only on its own commands
   assert_mode_cmd_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_cmd |=> $stable(mode_q));

   // R9: set command always activates
   assert_set_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && ex_op == 4'd12) |=> mode_q);
endmodule

bind lockstep_element lockstep_element_chk #(.WORD_W(WORD_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .issue_valid (issue_valid),
   .issue_ready (issue_ready),
   .ex_valid    (ex_valid),
   .ex_op       (ex_op),
   .mode_q      (mode_q),
   .ram_we      (ram_we),
   .acc_q       (acc_q),
   .route_q     (route_q)
);

// File: tb/lockstep_element_tb_top.sv
module lockstep_element_tb_top;
   localparam int W  = 64;
   localparam int AW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          issue_valid = 1'b0;
   logic [3:0]    issue_op = '0;
   logic [AW-1:0] issue_offset = '0;
   logic [1:0]    issue_lane = '0;
   logic [W-1:0]  bcast_word = '0;
   logic          issue_ready, active_out;
   logic [W-1:0]  acc_out, route_out;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   lockstep_element #(.WORD_W(W), .ADDR_W(AW)) dut_i (.*);

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] op, input logic [AW-1:0] off,
                        input logic [1:0] ln, input logic [W-1:0] d);
      @(negedge clk);
      issue_valid = 1'b1; issue_op = op; issue_offset = off; issue_lane = ln; bcast_word = d;
      @(negedge clk);
      issue_valid = 1'b0;
      @(negedge clk);
   endtask

   function automatic logic [W-1:0] lane_model(input logic [W-1:0] a, input logic [W-1:0] b,
                                               input logic [1:0] ln, input bit sub);
      logic [W-1:0] r;
      if (ln == 2'd1) begin
         for (int i = 0; i < 2; i++)
            r[i*32 +: 32] = sub ? a[i*32 +: 32] - b[i*32 +: 32] : a[i*32 +: 32] + b[i*32 +: 32];
      end else if (ln == 2'd2) begin
         for (int i = 0; i < 8; i++)
            r[i*8 +: 8] = sub ? a[i*8 +: 8] - b[i*8 +: 8] : a[i*8 +: 8] + b[i*8 +: 8];
      end else begin
         r = sub ? a - b : a + b;
      end
      return r;
   endfunction

   logic [W-1:0] pat_a [5] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_80FF_00FF,
                               64'h0123_4567_89AB_CDEF, 64'h0000_0000_FFFF_FFFF,
                               64'h8080_8080_8080_8080};
   logic [W-1:0] pat_b [5] = '{64'h0000_0000_0000_0001, 64'h0000_0001_8001_0101,
                               64'hFEDC_BA98_7654_3210, 64'h0000_0001_0000_0001,
                               64'h8080_8080_0101_0101};

   task automatic run_all();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 acc", acc_out, '0);
      check("R1 route", route_out, '0);
      check("R1 active", {63'd0, active_out}, 64'd1);
      check("R1 ready", {63'd0, issue_ready}, 64'd1);

      // R12: broadcast load, nop keeps it
      issue(4'd14, 0, 0, 64'hDEAD_BEEF_0BAD_F00D);
      check("R12 ldi", acc_out, 64'hDEAD_BEEF_0BAD_F00D);
      issue(4'd0, 0, 0, 64'h1);
      check("R12 nop", acc_out, 64'hDEAD_BEEF_0BAD_F00D);

      // R2: store/load at the two ends of memory
      issue(4'd14, 0, 0, 64'hA5A5_0000_0000_0001); issue(4'd6, 0, 0, 0);
      issue(4'd14, 0, 0, 64'h5A5A_FFFF_FFFF_FFFE); issue(4'd6, 2047, 0, 0);
      issue(4'd1, 0, 0, 0);
      check("R2 addr0", acc_out, 64'hA5A5_0000_0000_0001);
      issue(4'd1, 2047, 0, 0);
      check("R2 addr2047", acc_out, 64'h5A5A_FFFF_FFFF_FFFE);

      // R3: indexed address wraps modulo 2048
      issue(4'd14, 0, 0, 64'hFFFF_0000_0000_000A); issue(4'd9, 0, 0, 0);
      issue(4'd14, 0, 0, 64'h0000_0000_0000_ABCD); issue(4'd6, 2040, 0, 0);
      issue(4'd14, 0, 0, 0); issue(4'd9, 0, 0, 0);
      issue(4'd1, 2, 0, 0);
      check("R3 wrapped ea", acc_out, 64'h0000_0000_0000_ABCD);

      // R4 / R5: lane sweeps
      for (int p = 0; p < 5; p++) begin
         for (int ln = 0; ln < 4; ln++) begin
            for (int s = 0; s < 2; s++) begin
               issue(4'd14, 0, 0, pat_b[p]); issue(4'd6, 100, 0, 0);
               issue(4'd14, 0, 0, pat_a[p]);
               issue(s ? 4'd4 : 4'd3, 100, ln[1:0], 0);
               check(s ? "R5 lane sub" : "R4 lane add", acc_out,
                     lane_model(pat_a[p], pat_b[p], ln[1:0], s != 0));
            end
         end
      end

      // R6: logic ops and second-operand add
      issue(4'd14, 0, 0, 64'hF0F0_1234_FFFF_0000); issue(4'd6, 400, 0, 0);
      issue(4'd14, 0, 0, 64'h0FF0_FFFF_00FF_FFFF); issue(4'd7, 400, 0, 0);
      check("R6 and", acc_out, 64'h00F0_1234_00FF_0000);
      issue(4'd14, 0, 0, 64'h0FF0_FFFF_00FF_FFFF); issue(4'd8, 400, 0, 0);
      check("R6 xor", acc_out, 64'hFF00_EDCB_FF00_FFFF);
      issue(4'd14, 0, 0, 64'h01FF_80FF_7F01_FFFF); issue(4'd6, 401, 0, 0);
      issue(4'd2, 401, 0, 0);
      issue(4'd14, 0, 0, 64'hFF01_80FF_0101_0001);
      issue(4'd5, 0, 2, 0);
      check("R6 addb bytes", acc_out,
            lane_model(64'hFF01_80FF_0101_0001, 64'h01FF_80FF_7F01_FFFF, 2'd2, 1'b0));

      // R7: scratch and routing moves
      issue(4'd14, 0, 0, 64'h1357_9BDF_2468_ACE0); issue(4'd10, 0, 0, 0);
      issue(4'd14, 0, 0, 0); issue(4'd11, 0, 0, 0);
      check("R7 scratch", acc_out, 64'h1357_9BDF_2468_ACE0);
      issue(4'd15, 0, 0, 0);
      check("R7 route", route_out, 64'h1357_9BDF_2468_ACE0);

      // R8 / R9: inactive element
      issue(4'd14, 0, 0, 64'h5555); issue(4'd6, 201, 0, 0);
      issue(4'd14, 0, 0, 64'h1111);
      issue(4'd13, 0, 0, 0);
      check("R9 cleared", {63'd0, active_out}, 64'd0);
      issue(4'd14, 0, 0, 64'h2222);
      check("R8 ldi ignored", acc_out, 64'h1111);
      issue(4'd15, 0, 0, 0);
      check("R8 route held", route_out, 64'h1357_9BDF_2468_ACE0);
      issue(4'd6, 201, 0, 0);
      issue(4'd13, 0, 0, 0);
      check("R9 clear twice", {63'd0, active_out}, 64'd0);
      issue(4'd12, 0, 0, 0);
      check("R9 set while idle", {63'd0, active_out}, 64'd1);
      issue(4'd1, 201, 0, 0);
      check("R8 store suppressed", acc_out, 64'h5555);

      // R10: offer while busy is dropped
      @(negedge clk);
      issue_valid = 1'b1; issue_op = 4'd14; issue_lane = 0; issue_offset = 0;
      bcast_word = 64'hAAAA;
      @(negedge clk);
      check("R10 ready low", {63'd0, issue_ready}, 64'd0);
      bcast_word = 64'hBBBB;
      @(negedge clk);
      issue_valid = 1'b0;
      check("R10 first taken", acc_out, 64'hAAAA);
      @(negedge clk);
      check("R10 busy offer dropped", acc_out, 64'hAAAA);

      // R11: three-step vector add
      issue(4'd14, 0, 0, 64'h0000_0001_FFFF_FFFF); issue(4'd6, 301, 0, 0);
      issue(4'd14, 0, 0, 64'h0000_0002_0000_0001); issue(4'd6, 302, 0, 0);
      issue(4'd14, 0, 0, 0);
      issue(4'd1, 301, 0, 0); issue(4'd3, 302, 0, 0); issue(4'd6, 300, 0, 0);
      issue(4'd14, 0, 0, 0); issue(4'd1, 300, 0, 0);
      check("R11 vector add", acc_out, 64'h0000_0004_0000_0000);
   endtask

   initial begin
      fork
         run_all();
         begin
            #1000000;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule